// File: doc/BRIEF.md
# System-Management Interrupt Enable and Gating Register

This block is a 32-bit power-management control register on a plain I/O register bus. Each enable bit decides whether one event source may pull the active-low system-management interrupt line. Event sources latch into a companion status register. Software clears a status bit by writing 1 to it. The interrupt line stays low for as long as any enabled status bit is 1. A rerouted NMI also drives the line, and it does so whatever the TCO enable holds.

The register also has a write-only release bit and a software interrupt timer. Writing 1 to the release bit raises a global status flag, and that flag drives a control-interrupt request. Setting the timer enable starts a countdown. The countdown length is picked by a rate-select input from two cycle counts, and when it runs out the timer's status bit is set. Clearing the timer enable before the count ends restarts the timer and no interrupt is produced.

The bus decodes two offsets. The enable register is at 30h and the status register is at 34h. Reads return data one clock after the address is presented.

Top module: `pm_smi_ctl`

## Requirements
- R1: After reset both registers read 0, `smi_n` is 1 and `sci_req` is 0.
- R2: Only enable bits 18, 17, 14, 13, 11, 6 and 5 hold written values. All other enable bits, including bit 7, read 0 and ignore writes.
- R3: While `tco_lock` is 1, a write leaves enable bit 13 unchanged. The other bits still take the write.
- R4: When `nmi_reroute_en` is 1, an `nmi_evt` pulse sets status bit 15 and drives `smi_n` low, even if enable bit 13 is 0. When `nmi_reroute_en` is 0 the pulse has no effect.
- R5: Writing 1 to enable bit 7 sets status bit 0, and `sci_req` is 1 while that bit is 1. Writing 0 to bit 7 has no effect.
- R6: With enable bit 6 set, status bit 6 is set after a fixed number of cycles: `TMR_SHORT` when `rate_sel` is 0, `TMR_LONG` when it is 1. `smi_n` falls `TMR_X+1` clock edges after the edge that wrote the enable.
- R7: Clearing enable bit 6 before the timer expires restarts the timer. No timer status bit is set and no SMI follows.
- R8: An `apm_wr` pulse pulls `smi_n` low only while enable bit 5 is 1.
- R9: With enable bit 14 set, `smi_n` is low while status bit 14 is set by `periodic_evt`. With bit 14 clear, the periodic event leaves `smi_n` high.
- R10: Each gated source sets the status bit at its own enable position (18, 17, 14, 13, 11, 6, 5). `smi_n` is the registered NOR of all enabled status bits and status bit 15. It falls one edge after the status bit is set.
- R11: Writing 1s to the status register at 34h clears those bits, and `smi_n` returns high one edge after the clear. An event on the same edge as a clear wins.
- R12: `rdata` shows the register selected by `addr` one clock later. Addresses other than 30h and 34h read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| addr | input | ADDR_W | Register offset |
| wr_en | input | 1 | Write strobe |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Registered read data |
| tco_lock | input | 1 | Freezes enable bit 13 |
| nmi_reroute_en | input | 1 | Routes NMIs to SMI |
| nmi_evt | input | 1 | NMI event pulse |
| usb_vend_evt | input | 1 | Vendor USB2 event |
| usb_leg_evt | input | 1 | Legacy USB2 event |
| periodic_evt | input | 1 | Periodic event |
| tco_evt | input | 1 | TCO event |
| mc_trap_evt | input | 1 | Microcontroller range trap |
| apm_wr | input | 1 | Write to APM control port |
| rate_sel | input | 1 | Timer timeout select |
| smi_n | output | 1 | Active-low system-management interrupt |
| sci_req | output | 1 | Control-interrupt request |

## Verification
Each of the six gated sources is pulsed twice, once with its enable set and once with it clear. This tells a correct gate apart from a swapped or missing bit, and the matching status bit is then cleared to show that `smi_n` follows the clear. A walking-one sweep over all 32 enable bits separates the writable positions from the reserved positions and from the write-only bit. The timer is timed edge by edge at both rate selections and once more with an early cancel, which tells the two limits, an off-by-one count and a missing restart apart. The lock and NMI bypass are each tried with their control input at both values.

// File: rtl/pm_smi_pkg.sv
package pm_smi_pkg;
  localparam int REG_W  = 32;
  localparam int B_USBV = 18;
  localparam int B_USBL = 17;
  localparam int B_NMI  = 15;
  localparam int B_PER  = 14;
  localparam int B_TCO  = 13;
  localparam int B_MC   = 11;
  localparam int B_RLS  = 7;
  localparam int B_TMR  = 6;
  localparam int B_APM  = 5;
  localparam int B_GLB  = 0;

  localparam logic [REG_W-1:0] ONE = {{(REG_W-1){1'b0}}, 1'b1};
  // gated sources share bit positions between enable and status
  localparam logic [REG_W-1:0] EN_MASK =
    (ONE << B_USBV) | (ONE << B_USBL) | (ONE << B_PER) | (ONE << B_TCO) |
    (ONE << B_MC) | (ONE << B_TMR) | (ONE << B_APM);
  localparam logic [REG_W-1:0] ST_MASK = EN_MASK | (ONE << B_NMI) | (ONE << B_GLB);
endpackage

// File: rtl/pm_smi_enreg.sv
module pm_smi_enreg
  import pm_smi_pkg::*;
(
  input  logic             clk,
  input  logic             rst,
  input  logic             wr_hit,
  input  logic [REG_W-1:0] wdata,
  input  logic             tco_lock,
  output logic [REG_W-1:0] en_q,
  output logic             rls_pulse
);
  logic [REG_W-1:0] keep;

  always_comb begin
    keep = '0;
    keep[B_TCO] = tco_lock;
  end

  assign rls_pulse = wr_hit & wdata[B_RLS];

  always_ff @(posedge clk) begin
    if (rst) en_q <= '0;
    else if (wr_hit) en_q <= (wdata & EN_MASK & ~keep) | (en_q & keep);
  end
endmodule

// File: rtl/pm_smi_timer.sv
module pm_smi_timer #(
  parameter int TMR_SHORT = 8,
  parameter int TMR_LONG  = 20
) (
  input  logic clk,
  input  logic rst,
  input  logic run,
  input  logic rate_sel,
  output logic expire
);
  localparam int MAXV  = (TMR_SHORT > TMR_LONG) ? TMR_SHORT : TMR_LONG;
  localparam int CNT_W = $clog2(MAXV + 1);

  logic [CNT_W-1:0] tmr_cnt;
  logic [CNT_W-1:0] last;

  assign last   = rate_sel ? CNT_W'(TMR_LONG - 1) : CNT_W'(TMR_SHORT - 1);
  assign expire = run && (tmr_cnt >= last);

  always_ff @(posedge clk) begin
    if (rst || !run) tmr_cnt <= '0;
    else if (expire) tmr_cnt <= '0;
    else tmr_cnt <= tmr_cnt + 1'b1;
  end
endmodule

// File: rtl/pm_smi_status.sv
module pm_smi_status
  import pm_smi_pkg::*;
(
  input  logic             clk,
  input  logic             rst,
  input  logic [REG_W-1:0] evt,
  input  logic             clr_hit,
  input  logic [REG_W-1:0] wdata,
  input  logic [REG_W-1:0] en,
  output logic [REG_W-1:0] sts_q,
  output logic             smi_n
);
  logic [REG_W-1:0] clr_v;
  logic             pending;

  assign clr_v   = clr_hit ? (wdata & ST_MASK) : '0;
  assign pending = (|(sts_q & en & EN_MASK)) | sts_q[B_NMI];

  always_ff @(posedge clk) begin
    if (rst) begin
      sts_q <= '0;
      smi_n <= 1'b1;
    end else begin
      sts_q <= (sts_q & ~clr_v) | (evt & ST_MASK);
      smi_n <= ~pending;
    end
  end
endmodule

// File: rtl/pm_smi_ctl.sv
module pm_smi_ctl
  import pm_smi_pkg::*;
#(
  parameter int              ADDR_W    = 8,
  parameter logic [ADDR_W-1:0] EN_OFF  = 8'h30,
  parameter logic [ADDR_W-1:0] ST_OFF  = 8'h34,
  parameter int              TMR_SHORT = 8,
  parameter int              TMR_LONG  = 20
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [ADDR_W-1:0] addr,
  input  logic              wr_en,
  input  logic [31:0]       wdata,
  output logic [31:0]       rdata,
  input  logic              tco_lock,
  input  logic              nmi_reroute_en,
  input  logic              nmi_evt,
  input  logic              usb_vend_evt,
  input  logic              usb_leg_evt,
  input  logic              periodic_evt,
  input  logic              tco_evt,
  input  logic              mc_trap_evt,
  input  logic              apm_wr,
  input  logic              rate_sel,
  output logic              smi_n,
  output logic              sci_req
);
  logic             en_hit, st_hit, rls_pulse, tmr_exp;
  logic [REG_W-1:0] en_q, sts_q, evt;

  assign en_hit = wr_en && (addr == EN_OFF);
  assign st_hit = wr_en && (addr == ST_OFF);

  pm_smi_enreg u_en (
    .clk(clk), .rst(rst), .wr_hit(en_hit), .wdata(wdata),
    .tco_lock(tco_lock), .en_q(en_q), .rls_pulse(rls_pulse)
  );

  pm_smi_timer #(.TMR_SHORT(TMR_SHORT), .TMR_LONG(TMR_LONG)) u_tmr (
    .clk(clk), .rst(rst), .run(en_q[B_TMR]), .rate_sel(rate_sel), .expire(tmr_exp)
  );

  always_comb begin
    evt         = '0;
    evt[B_USBV] = usb_vend_evt;
    evt[B_USBL] = usb_leg_evt;
    evt[B_NMI]  = nmi_evt & nmi_reroute_en;
    evt[B_PER]  = periodic_evt;
    evt[B_TCO]  = tco_evt;
    evt[B_MC]   = mc_trap_evt;
    evt[B_TMR]  = tmr_exp;
    evt[B_APM]  = apm_wr;
    evt[B_GLB]  = rls_pulse;
  end

  pm_smi_status u_st (
    .clk(clk), .rst(rst), .evt(evt), .clr_hit(st_hit), .wdata(wdata),
    .en(en_q), .sts_q(sts_q), .smi_n(smi_n)
  );

  assign sci_req = sts_q[B_GLB];

  always_ff @(posedge clk) begin
    if (rst) rdata <= '0;
    else if (addr == EN_OFF) rdata <= en_q;
    else if (addr == ST_OFF) rdata <= sts_q;
    else rdata <= '0;
  end
endmodule

// File: rtl/pm_smi_chk.sv
module pm_smi_chk
  import pm_smi_pkg::*;
#(
  parameter int                ADDR_W = 8,
  parameter logic [ADDR_W-1:0] EN_OFF = 8'h30
) (
  input logic              clk,
  input logic              rst,
  input logic [ADDR_W-1:0] addr,
  input logic              wr_en,
  input logic [31:0]       wdata,
  input logic [31:0]       rdata,
  input logic              tco_lock,
  input logic [31:0]       en_q,
  input logic [31:0]       sts_q,
  input logic              smi_n,
  input logic              sci_req
);
  assert_tco_hold_R3: assert property (@(posedge clk) disable iff (rst)
    tco_lock |=> $stable(en_q[B_TCO]));

  assert_rls_reads_zero_R2: assert property (@(posedge clk) disable iff (rst)
    (addr == EN_OFF) |=> (rdata[B_RLS] == 1'b0));

  assert_rls_sets_flag_R5: assert property (@(posedge clk) disable iff (rst)
    (wr_en && addr == EN_OFF && wdata[B_RLS]) |=> sci_req);

  assert_smi_has_cause_R10: assert property (@(posedge clk) disable iff (rst)
    !smi_n |-> $past(sts_q != '0));

  assert_reserved_clear_R2: assert property (@(posedge clk) disable iff (rst)
    $past(wr_en && addr == EN_OFF) |-> ((en_q & ~EN_MASK) == '0));
endmodule

bind pm_smi_ctl pm_smi_chk #(.ADDR_W(ADDR_W), .EN_OFF(EN_OFF)) u_chk (
  .clk(clk), .rst(rst), .addr(addr), .wr_en(wr_en), .wdata(wdata),
  .rdata(rdata), .tco_lock(tco_lock), .en_q(en_q), .sts_q(sts_q),
  .smi_n(smi_n), .sci_req(sci_req)
);

// File: tb/sim_pm_smi_ctl.sv
module sim_pm_smi_ctl;
  localparam int SHORT = 8;
  localparam int LONG  = 20;
  localparam logic [7:0] ENA = 8'h30;
  localparam logic [7:0] STA = 8'h34;
  localparam logic [31:0] RW_BITS = (32'd1<<18)|(32'd1<<17)|(32'd1<<14)|
                                    (32'd1<<13)|(32'd1<<11)|(32'd1<<6)|(32'd1<<5);

  logic clk = 0, rst = 1;
  logic [7:0] addr = 0;
  logic wr_en = 0;
  logic [31:0] wdata = 0, rdata;
  logic tco_lock = 0, nmi_reroute_en = 0, nmi_evt = 0, rate_sel = 0;
  logic [5:0] src = 0;
  logic smi_n, sci_req;
  int errors = 0, checks = 0;
  bit done = 0;

  always #5 clk = ~clk;

  pm_smi_ctl #(.TMR_SHORT(SHORT), .TMR_LONG(LONG)) u0 (
    .clk(clk), .rst(rst), .addr(addr), .wr_en(wr_en), .wdata(wdata), .rdata(rdata),
    .tco_lock(tco_lock), .nmi_reroute_en(nmi_reroute_en), .nmi_evt(nmi_evt),
    .usb_vend_evt(src[0]), .usb_leg_evt(src[1]), .periodic_evt(src[2]),
    .tco_evt(src[3]), .mc_trap_evt(src[4]), .apm_wr(src[5]),
    .rate_sel(rate_sel), .smi_n(smi_n), .sci_req(sci_req)
  );

  function automatic int srcpos(int i);
    case (i)
      0: return 18; 1: return 17; 2: return 14;
      3: return 13; 4: return 11; default: return 5;
    endcase
  endfunction

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic wr(logic [7:0] a, logic [31:0] d);
    addr = a; wdata = d; wr_en = 1;
    @(negedge clk);
    wr_en = 0; wdata = 0;
  endtask

  task automatic rd(logic [7:0] a, output logic [31:0] d);
    addr = a;
    @(negedge clk);
    d = rdata;
  endtask

  initial begin
    logic [31:0] v;
    int n;
    @(negedge clk); @(negedge clk);
    rst = 0;
    // R1 reset state
    chk("R1 smi_n", smi_n, 1);
    chk("R1 sci_req", sci_req, 0);
    rd(ENA, v); chk("R1 enable", v, 0);
    rd(STA, v); chk("R1 status", v, 0);
    rd(8'h20, v); chk("R12 unmapped", v, 0);

    // R2 walking one over every bit
    for (int i = 0; i < 32; i++) begin
      wr(ENA, 32'd1 << i);
      rd(ENA, v);
      chk($sformatf("R2 bit %0d", i), v, (32'd1 << i) & RW_BITS);
      wr(ENA, 0);
      wr(STA, 32'hFFFF_FFFF);
    end
    wr(ENA, 32'hFFFF_FFFF); rd(ENA, v); chk("R2 all ones", v, RW_BITS);
    wr(ENA, 0); wr(STA, 32'hFFFF_FFFF); @(negedge clk);
    chk("R11 smi_n after clear", smi_n, 1);

    // R10/R8/R9 each gated source, enabled and disabled
    for (int i = 0; i < 6; i++) begin
      for (int e = 0; e < 2; e++) begin
        wr(ENA, e ? (32'd1 << srcpos(i)) : 32'd0);
        src[i] = 1; @(negedge clk); src[i] = 0; @(negedge clk);
        chk($sformatf("R10 R8 R9 src %0d en %0d smi_n", i, e), smi_n, e ? 0 : 1);
        rd(STA, v);
        chk($sformatf("R10 src %0d status", i), v, 32'd1 << srcpos(i));
        wr(STA, 32'd1 << srcpos(i)); @(negedge clk);
        chk($sformatf("R11 src %0d cleared", i), smi_n, 1);
      end
    end
    wr(ENA, 0);

    // R11 event on same edge as clear wins
    wr(ENA, 32'd1 << 11);
    src[4] = 1; wr(STA, 32'd1 << 11); src[4] = 0; @(negedge clk);
    chk("R11 set wins over clear", smi_n, 0);
    wr(STA, 32'd1 << 11); @(negedge clk);
    wr(ENA, 0);

    // R3 lock on bit 13
    wr(ENA, 32'd1 << 13);
    tco_lock = 1;
    wr(ENA, 32'd1 << 5); rd(ENA, v);
    chk("R3 locked keeps bit13", v, (32'd1 << 13) | (32'd1 << 5));
    tco_lock = 0;
    wr(ENA, 0); rd(ENA, v); chk("R3 unlocked clears", v, 0);

    // R4 NMI bypass
    nmi_evt = 1; @(negedge clk); nmi_evt = 0; @(negedge clk);
    chk("R4 no reroute", smi_n, 1);
    nmi_reroute_en = 1;
    nmi_evt = 1; @(negedge clk); nmi_evt = 0; @(negedge clk);
    chk("R4 reroute smi_n", smi_n, 0);
    rd(STA, v); chk("R4 status15", v, 32'd1 << 15);
    wr(STA, 32'd1 << 15); @(negedge clk); nmi_reroute_en = 0;

    // R5 release bit
    wr(ENA, 32'd1 << 7);
    chk("R5 sci_req set", sci_req, 1);
    rd(ENA, v); chk("R5 reads zero", v, 0);
    wr(STA, 32'd1); chk("R5 flag cleared", sci_req, 0);
    wr(ENA, 0); chk("R5 zero no effect", sci_req, 0);

    // R6 timer at both rates
    for (int r = 0; r < 2; r++) begin
      rate_sel = r[0];
      wr(ENA, 32'd1 << 6);
      n = 0;
      while (smi_n && n < 100) begin @(negedge clk); n++; end
      chk($sformatf("R6 rate %0d edges", r), n, (r ? LONG : SHORT) + 1);
      wr(ENA, 0); wr(STA, 32'd1 << 6); @(negedge clk);
    end
    rate_sel = 0;

    // R7 cancel before expiry
    wr(ENA, 32'd1 << 6);
    repeat (SHORT - 3) @(negedge clk);
    wr(ENA, 0);
    repeat (2 * SHORT) @(negedge clk);
    chk("R7 no smi", smi_n, 1);
    rd(STA, v); chk("R7 no status", v, 0);
    wr(ENA, 32'd1 << 6);
    repeat (SHORT - 1) @(negedge clk);
    chk("R7 restarted full count", smi_n, 1);
    wr(ENA, 0); wr(STA, 32'hFFFF_FFFF);
    done = 1;
  end

  initial begin
    fork
      wait (done);
      begin repeat (20000) @(posedge clk); errors++; checks++;
        $display("FAIL watchdog expired"); end
    join_any
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule